// File: doc/BRIEF.md
# Byte-Pair SPI Register Slave

This block lets an external host read and write a 128-entry, 8-bit register file over a 4-wire serial link. The link has a serial clock, an active-low select, a data input and a data output. Every access is one framed pair of bytes. The first byte holds a direction flag and a 7-bit register index. The second byte carries the write value from the host, or the read value to the host. The register file sits outside the block. It is reached through a strobed read/write port with a combinational read-data return.

The serial inputs are brought into the block's own clock domain through a parameterised flop chain. SCLK edges are detected on the synchronised copy, so the whole frame runs on `clk_i`. Data moves MSB first. SDI is taken on rising SCLK edges, and SDO advances on falling edges. SDO has a separate enable that marks when the pin would be driven.

Top module: `spi_pair_slave`

## Requirements
- R1: After reset, `reg_we_o`, `reg_re_o`, `sdo_oe_o` and `sdo_o` are all 0.
- R2: `sclk_i`, `cs_ni` and `sdi_i` pass through `SYNC_STAGES` flops before use. SDI is shifted in MSB first on each synchronised rising SCLK edge. Each SCLK phase must last at least `SYNC_STAGES`+2 clock cycles.
- R3: In the first byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6..0 are the register index. `reg_addr_o` carries that index from the cycle after the eighth rising edge onward.
- R4: On a read, `reg_re_o` pulses for exactly one cycle, in the cycle after the eighth synchronised rising edge. `reg_rdata_i` is captured in that cycle.
- R5: On a read, the captured byte leaves on SDO MSB first. A new bit appears after each synchronised falling edge that follows the eighth rising edge, so the host sees bit 7 before its ninth rising edge.
- R6: On a write, `reg_we_o` pulses for one cycle with `reg_wdata_o` valid. The pulse comes in the cycle after the sixteenth synchronised rising edge and never earlier.
- R7: A release of select before the sixteenth rising edge, or in the same synchronised cycle as it, aborts the access. No write happens, and the next access starts again at bit 0.
- R8: `sdo_oe_o` is 1 only while select is held during the data byte of a read. It is 0 during the command byte, throughout a write, and whenever select is released. `sdo_o` reads 0 while `sdo_oe_o` is 0.
- R9: Rising edges after the sixteenth within one select window are ignored. No further strobe is issued and the register file is left unchanged.
- R10: `reg_re_o` and `reg_we_o` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host (idle low) |
| cs_ni | input | 1 | Select, active low |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Drive enable for SDO |
| reg_addr_o | output | 7 | Register index |
| reg_re_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | 8 | Read data, valid in the strobe cycle |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_wdata_o | output | 8 | Write data, valid with the write strobe |

## Verification
The release of select can land in the same synchronised cycle as the sixteenth rising SCLK edge. In that cycle the abort and the write commit compete. The bench provokes this by raising SCLK and select in the same clock cycle at the end of a write frame. It then judges that no write strobe appeared and that the target register kept its old value. A behavioural model steps alongside the design and compares strobes, index, write data, SDO and its enable on every clock. This catches a commit that slips through the abort, and also a counter that is not cleared for the next frame.

// File: rtl/spi_pair_pkg.sv
package spi_pair_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = DATA_W - 1;
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic sdi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_act_o,
  output logic sdi_o
);
  logic [STAGES-1:0] sclk_p, cs_p, sdi_p;
  logic              sclk_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sclk_p <= '0;
          cs_p   <= '1;
          sdi_p  <= '0;
        end else begin
          sclk_p <= sclk_i;
          cs_p   <= cs_ni;
          sdi_p  <= sdi_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sclk_p <= '0;
          cs_p   <= '1;
          sdi_p  <= '0;
        end else begin
          sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
          cs_p   <= {cs_p[STAGES-2:0], cs_ni};
          sdi_p  <= {sdi_p[STAGES-2:0], sdi_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_p[STAGES-1];
  end

  assign sclk_rise_o = sclk_p[STAGES-1] & ~sclk_prev_q;
  assign sclk_fall_o = ~sclk_p[STAGES-1] & sclk_prev_q;
  assign cs_act_o    = ~cs_p[STAGES-1];
  assign sdi_o       = sdi_p[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_pair_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              data_phase_o,
  output logic              re_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] DATA_BASE = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, rx_next;
  cmd_t              cmd_q;
  logic              re_q, we_q;
  logic [DATA_W-1:0] wdata_q;

  assign rx_next = {rx_q[DATA_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rx_q    <= '0;
      cmd_q   <= '0;
      re_q    <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      re_q <= 1'b0;
      we_q <= 1'b0;
      if (!cs_act_i) begin
        cnt_q <= '0;
        rx_q  <= '0;
      end else if (rise_i && cnt_q < CNT_FULL) begin
        rx_q  <= rx_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CMD_LAST) begin
          cmd_q <= cmd_t'(rx_next);
          re_q  <= rx_next[DATA_W-1];
        end
        if (cnt_q == DATA_LAST && !cmd_q.rd) begin
          we_q    <= 1'b1;
          wdata_q <= rx_next;
        end
      end
    end
  end

  assign addr_o       = cmd_q.addr;
  assign rd_o         = cmd_q.rd;
  assign data_phase_o = cs_act_i && (cnt_q >= DATA_BASE);
  assign re_o         = re_q;
  assign we_o         = we_q;
  assign wdata_o      = wdata_q;

  // R7
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> cnt_q == '0);
  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  // R6
  we_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (cnt_q == CNT_FULL || !cs_act_i) && !cmd_q.rd);
  // R4
  re_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_q |-> cmd_q.rd);
  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_q && we_q));
  // R10
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_q |=> !re_q);
  // R10
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_pair_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              shift_i,
  input  logic              clear_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] tx_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (load_i)       tx_q <= din_i;
      else if (shift_i) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (clear_i)      sdo_q <= 1'b0;
      else if (shift_i) sdo_q <= tx_q[DATA_W-1];
    end
  end

  assign sdo_o = sdo_q;

  // R4
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> tx_q == $past(din_i));
  // R2
  no_load_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/spi_pair_slave.sv
module spi_pair_slave
  import spi_pair_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  logic rise, fall, cs_act, sdi_s;
  logic rd, data_phase, sdo_raw;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .sdi_i       (sdi_i),
    .sclk_rise_o (rise),
    .sclk_fall_o (fall),
    .cs_act_o    (cs_act),
    .sdi_o       (sdi_s)
  );

  spi_frame_rx u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_act_i     (cs_act),
    .rise_i       (rise),
    .sdi_i        (sdi_s),
    .addr_o       (reg_addr_o),
    .rd_o         (rd),
    .data_phase_o (data_phase),
    .re_o         (reg_re_o),
    .we_o         (reg_we_o),
    .wdata_o      (reg_wdata_o)
  );

  spi_tx_shift u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (reg_re_o),
    .din_i   (reg_rdata_i),
    .shift_i (fall && data_phase && rd),
    .clear_i (!cs_act),
    .sdo_o   (sdo_raw)
  );

  assign sdo_oe_o = data_phase && rd;
  assign sdo_o    = sdo_oe_o ? sdo_raw : 1'b0;

  // R8
  oe_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !sdo_oe_o);
  // R8
  oe_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> sdo_oe_o || !cs_act);
endmodule

// File: tb/spi_pair_slave_tb.sv
module spi_pair_slave_tb;
  localparam int SYNC = 2;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drv_sclk = 1'b0, drv_cs = 1'b1, drv_sdi = 1'b0;
  logic       sdo, sdo_oe, re, we;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [128];

  int checks = 0, errors = 0;
  int oe_seen = 0, we_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_pair_slave #(.SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(drv_sclk), .cs_ni(drv_cs), .sdi_i(drv_sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_addr_o(addr), .reg_re_o(re),
    .reg_rdata_i(rdata), .reg_we_o(we), .reg_wdata_o(wdata)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit   sc_p[SYNC], cs_p[SYNC], sd_p[SYNC];
  bit   m_prev, m_re, m_we, m_sdo;
  int   m_cnt, m_rx, m_cmd, m_wd, m_tx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) begin sc_p[k] = 0; cs_p[k] = 1; sd_p[k] = 0; end
      m_prev = 0; m_re = 0; m_we = 0; m_sdo = 0;
      m_cnt = 0; m_rx = 0; m_cmd = 0; m_wd = 0; m_tx = 0;
    end else begin
      bit s_sc, s_cs, s_sd, rs, fl, n_re, n_we;
      s_sc = sc_p[SYNC-1]; s_cs = cs_p[SYNC-1]; s_sd = sd_p[SYNC-1];
      rs = s_sc && !m_prev;
      fl = !s_sc && m_prev;
      n_re = 0; n_we = 0;
      if (m_re) m_tx = int'(mem[m_cmd & 8'h7f]);
      if (s_cs) begin
        m_cnt = 0; m_rx = 0; m_sdo = 0;
      end else begin
        if (rs && m_cnt < 16) begin
          m_rx = ((m_rx << 1) | int'(s_sd)) & 8'hff;
          if (m_cnt == 7) begin m_cmd = m_rx; n_re = m_rx[7]; end
          if (m_cnt == 15 && !m_cmd[7]) begin n_we = 1; m_wd = m_rx; end
          m_cnt++;
        end
        if (fl && m_cmd[7] && m_cnt >= 8 && !m_re) begin
          m_sdo = m_tx[7];
          m_tx = (m_tx << 1) & 8'hff;
        end
      end
      m_re = n_re; m_we = n_we;
      for (int k = SYNC-1; k > 0; k--) begin sc_p[k] = sc_p[k-1]; cs_p[k] = cs_p[k-1]; sd_p[k] = sd_p[k-1]; end
      sc_p[0] = drv_sclk; cs_p[0] = drv_cs; sd_p[0] = drv_sdi;
      m_prev = s_sc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_oe;
      e_oe = !cs_p[SYNC-1] && m_cmd[7] && m_cnt >= 8;
      if (sdo_oe) oe_seen++;
      if (we) we_seen++;
      chk(re == m_re, "R4 re strobe", re, m_re);
      chk(we == m_we, "R6 we strobe", we, m_we);
      chk(!(re && we), "R10 strobe overlap", {re, we}, 0);
      chk(sdo_oe == e_oe, "R8 sdo_oe", sdo_oe, e_oe);
      chk(sdo == (e_oe && m_sdo), "R5 sdo", sdo, e_oe && m_sdo);
      if (re || we) chk(addr == m_cmd[6:0], "R3 reg_addr", addr, m_cmd & 8'h7f);
      if (we) chk(wdata == m_wd[7:0], "R6 wdata", wdata, m_wd);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int nbits, input logic [23:0] word, input bit abort_last,
                      output logic [7:0] got);
    got = '0;
    @(negedge clk); drv_cs = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < nbits; i++) begin
      drv_sdi = word[nbits-1-i];
      wait_n(HALF);
      if (i >= 8 && i < 16) got = {got[6:0], sdo};
      if (abort_last && i == nbits-1) drv_cs = 1'b1;
      drv_sclk = 1'b1;
      wait_n(HALF);
      drv_sclk = 1'b0;
    end
    wait_n(HALF);
    drv_cs = 1'b1;
    wait_n(3 * HALF);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] got;
    int w0, o0;
    for (int k = 0; k < 128; k++) mem[k] = 8'(k * 3 + 1);
    wait_n(4);
    // R1
    chk(we == 0 && re == 0, "R1 strobes in reset", {re, we}, 0);
    chk(sdo_oe == 0 && sdo == 0, "R1 sdo in reset", {sdo_oe, sdo}, 0);
    rst_n = 1'b1;
    wait_n(4);
    chk(we == 0 && re == 0 && sdo_oe == 0 && sdo == 0, "R1 idle after reset",
        {re, we, sdo_oe, sdo}, 0);

    // R2 R6: write 0xA5 to index 5
    o0 = oe_seen;
    xfer(16, {8'h00, 8'h05, 8'hA5}, 0, got);
    chk(mem[5] == 8'hA5, "R2 R6 write MSB first", mem[5], 8'hA5);
    chk(oe_seen == o0, "R8 no oe during write", oe_seen - o0, 0);

    // R5: read back
    xfer(16, {8'h00, 8'h85, 8'h00}, 0, got);
    chk(got == 8'hA5, "R5 read data", got, 8'hA5);

    // R3: index boundaries
    xfer(16, {8'h00, 8'h7F, 8'h3C}, 0, got);
    xfer(16, {8'h00, 8'hFF, 8'h00}, 0, got);
    chk(got == 8'h3C && mem[127] == 8'h3C, "R3 top index", got, 8'h3C);
    xfer(16, {8'h00, 8'h00, 8'hFF}, 0, got);
    xfer(16, {8'h00, 8'h80, 8'h00}, 0, got);
    chk(got == 8'hFF && mem[0] == 8'hFF, "R3 index zero", got, 8'hFF);

    // R4: read of a value placed directly
    mem[9] = 8'h81;
    xfer(16, {8'h00, 8'h89, 8'h00}, 0, got);
    chk(got == 8'h81, "R4 read captures rdata", got, 8'h81);

    // R7: release after twelve bits
    w0 = we_seen;
    xfer(12, {12'h0, 12'h050}, 0, got);
    chk(mem[5] == 8'hA5 && we_seen == w0, "R7 early release no write", mem[5], 8'hA5);
    xfer(16, {8'h00, 8'h85, 8'h00}, 0, got);
    chk(got == 8'hA5, "R7 next frame from bit 0", got, 8'hA5);

    // R7: release together with the sixteenth rising edge
    w0 = we_seen;
    xfer(16, {8'h00, 8'h05, 8'h00}, 1, got);
    chk(mem[5] == 8'hA5 && we_seen == w0, "R7 same-cycle release", mem[5], 8'hA5);

    // R9: extra bits after the frame
    w0 = we_seen;
    xfer(24, {8'h06, 8'h55, 8'hAA}, 0, got);
    chk(mem[6] == 8'h55, "R9 extra bits ignored", mem[6], 8'h55);
    chk(we_seen == w0 + 1, "R9 single write strobe", we_seen - w0, 1);

    // R8: oe seen during a read data byte
    o0 = oe_seen;
    xfer(16, {8'h00, 8'h86, 8'h00}, 0, got);
    chk(oe_seen > o0 && got == 8'h55, "R8 oe on read", got, 8'h55);
    chk(sdo_oe == 0 && sdo == 0, "R8 idle after release", {sdo_oe, sdo}, 0);

    done = 1;
    finish_run();
  end
endmodule